// File: doc/BRIEF.md
# Dual-Mode General-Purpose Timer

This block is a 32-bit up-counting timer for a peripheral subsystem. Software drives it through a small synchronous register bus. Through that bus it can:

- start and stop the counter, and read or write the counter directly;
- choose whether an overflow reloads a preset value or wraps the counter to zero and halts it;
- force a reload from the preset value by writing any data to a trigger address;
- slow the count with a power-of-two prescaler.

The timer can compare the running count against a match value. It latches the count when a chosen edge appears on a capture pin. It shapes an output pin as a pulse or a toggle on overflow and match events. That pin can also be driven as a plain general-purpose level.

The three event sources (match, overflow, capture) set sticky status bits, and software clears a bit by writing 1 to it. Each bit has an interrupt enable and a wakeup enable, and these produce the two request outputs.

A soft reset is governed by a two-state machine. `ST_READY` is the normal operating state. A write to the interface-control address with bit 1 set takes the transition `go_reset` to `ST_SRST`. The machine then holds `ST_SRST` for `SRST_CYCLES` clocks and takes the transition `reset_done` back to `ST_READY`. While in `ST_SRST` every register is held at its reset value and bus writes are ignored.

Top module: `dmt_timer`

## Requirements
- R1: After hard reset, the following all read 0: control (0x24), counter (0x28), load (0x2C), match (0x38), status (0x18) and capture (0x3C). Bit 0 of the system status word (0x14) reads 1, and `irq_o`, `wake_o` and `pwm_o` are 0.
- R2: While control bit 0 (run) is 1, the counter advances by one on each count tick. While run is 0 the counter holds. A bus write to the counter takes priority over a tick in the same cycle, and that cycle then produces no advance and no event.
- R3: With control bit 5 set, a count tick occurs once every 2^(v+1) clocks, where v is control bits 4:2. With bit 5 clear, a tick occurs every clock.
- R4: A tick with the counter at 0xFFFFFFFF sets status bit 1. If control bit 1 (auto-reload) is set, the counter then takes the load value.
- R5: On that overflow with auto-reload clear, the counter wraps to 0 and control bit 0 clears, so counting stops.
- R6: Any bus write to the trigger address 0x30 copies the load value into the counter, whatever the write data is.
- R7: With control bit 6 set, a tick that brings the counter to the match value sets status bit 0. With bit 6 clear, no match status is set.
- R8: Control bits 9:8 select the capture edge on `capt_i`: 01 rising, 10 falling, 11 both, 00 none. The pin passes through a two-flop synchronizer. A selected edge copies the counter into the capture register (0x3C) and sets status bit 2, and an edge that is not selected does neither.
- R9: With control bit 13 set, a capture is taken only while status bit 2 is clear, so the first captured value is held until software clears that bit. With bit 13 clear, every selected edge updates the capture register.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. When an event sets a bit in the same cycle as a clear of that bit, the bit ends set.
- R11: `irq_o` is high whenever a status bit is set together with its bit in the interrupt-enable register (0x1C). `wake_o` follows the same rule using the wakeup-enable register (0x20).
- R12: Control bits 11:10 select the output events: 00 none, 01 overflow only, 10 or 11 overflow and match. With bit 12 set, each selected event inverts `pwm_o`. With bit 12 clear, each selected event drives `pwm_o` away from the default level (bit 7) for one clock.
- R13: With control bit 14 set, `pwm_o` equals control bit 7 regardless of events. With 00 in bits 11:10, `pwm_o` equals control bit 7.
- R14: Writing a value with bit 1 set to 0x40 starts a soft reset. Bit 0 of 0x14 reads 0 for `SRST_CYCLES` clocks and then reads 1. All registers return to their reset values, and bus writes during that window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| capt_i | input | 1 | Asynchronous capture pin |
| pwm_o | output | 1 | Event-shaped or general-purpose output pin |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The status register can receive an event-driven set from the counter and a software clear from the bus on the same clock edge. The bench provokes this by starting the counter a known number of ticks below the match value and timing a status write that clears both the match bit and a previously set capture bit so that it lands on the edge where the match occurs. The check requires that the match bit stays set while the capture bit clears. A second collision, a counter write that lands on a counting edge, is judged by requiring that the written value wins and then advances by exactly one on the following tick.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam logic [7:0] A_SYSST = 8'h14;
    localparam logic [7:0] A_STAT  = 8'h18;
    localparam logic [7:0] A_IEN   = 8'h1C;
    localparam logic [7:0] A_WEN   = 8'h20;
    localparam logic [7:0] A_CTRL  = 8'h24;
    localparam logic [7:0] A_CNT   = 8'h28;
    localparam logic [7:0] A_LOAD  = 8'h2C;
    localparam logic [7:0] A_TRIG  = 8'h30;
    localparam logic [7:0] A_MATCH = 8'h38;
    localparam logic [7:0] A_CAPT  = 8'h3C;
    localparam logic [7:0] A_IFC   = 8'h40;

    localparam int PV_W   = 3;
    localparam int STAT_W = 3;
    localparam int S_MATCH = 0;
    localparam int S_OVF   = 1;
    localparam int S_CAPT  = 2;

    // control word, bit 0 is the LSB (run)
    typedef struct packed {
        logic            gpo;
        logic            cap_hold;
        logic            toggle;
        logic [1:0]      trig_mode;
        logic [1:0]      edge_sel;
        logic            def_lvl;
        logic            cmp_en;
        logic            pre_en;
        logic [PV_W-1:0] pre_val;
        logic            reload;
        logic            run;
    } ctrl_t;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_SRST  = 1'b1
    } srst_state_e;

endpackage

// File: rtl/dmt_prescale.sv
module dmt_prescale #(
    parameter int PV_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic            pre_en,
    input  logic [PV_W-1:0] pre_val,
    output logic            tick
);
    localparam int DIV_W = 1 << PV_W;

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] lim;

    // terminal value is 2^(v+1)-1: v+1 ones from the LSB
    always_comb begin
        lim = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i[PV_W-1:0] <= pre_val) lim[i] = 1'b1;
        end
    end

    assign tick = run && (!pre_en || (pcnt == lim));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr || !run || !pre_en) begin
            pcnt <= '0;
        end else if (pcnt == lim) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/dmt_capsync.sv
module dmt_capsync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    logic rise, fall;
    assign rise = s2 && !s3;
    assign fall = !s2 && s3;
    assign hit  = (edge_sel[0] && rise) || (edge_sel[1] && fall);
endmodule

// File: rtl/dmt_pwm.sv
module dmt_pwm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       def_lvl,
    input  logic       gpo,
    input  logic       toggle,
    input  logic [1:0] trig_mode,
    input  logic       ovf_evt,
    input  logic       match_evt,
    output logic       pwm_o
);
    logic evt, tog, pls;

    always_comb begin
        unique case (trig_mode)
            2'b00:   evt = 1'b0;
            2'b01:   evt = ovf_evt;
            default: evt = ovf_evt || match_evt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog <= 1'b0;
            pls <= 1'b0;
        end else if (clr) begin
            tog <= 1'b0;
            pls <= 1'b0;
        end else begin
            pls <= evt;
            if (trig_mode == 2'b00) tog <= 1'b0;
            else if (evt)           tog <= !tog;
        end
    end

    assign pwm_o = gpo ? def_lvl : (def_lvl ^ (toggle ? tog : pls));
endmodule

// File: rtl/dmt_timer.sv
module dmt_timer
    import dmt_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 32,
    parameter int SRST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          capt_i,
    output logic          pwm_o,
    output logic          irq_o,
    output logic          wake_o
);
    localparam int CW   = $bits(ctrl_t);
    localparam int CD_W = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;

    srst_state_e state, state_nxt;
    logic [CD_W-1:0] cd;
    logic rdy, srst_go, clr;

    ctrl_t              ctrl;
    logic [DW-1:0]      cnt, load_v, match_v, capt_v, cnt_adv;
    logic [STAT_W-1:0]  stat, ien, wen, stat_clr, stat_set;
    logic tick, at_top, cnt_wr, ovf_evt, match_evt, cap_hit, cap_take;
    logic wr_stat, wr_ien, wr_wen, wr_ctrl, wr_cnt, wr_load, wr_trig, wr_match, wr_ifc;

    // ---------------- bus write decode ----------------
    assign wr_stat  = bus_we && rdy && (bus_addr == AW'(A_STAT));
    assign wr_ien   = bus_we && rdy && (bus_addr == AW'(A_IEN));
    assign wr_wen   = bus_we && rdy && (bus_addr == AW'(A_WEN));
    assign wr_ctrl  = bus_we && rdy && (bus_addr == AW'(A_CTRL));
    assign wr_cnt   = bus_we && rdy && (bus_addr == AW'(A_CNT));
    assign wr_load  = bus_we && rdy && (bus_addr == AW'(A_LOAD));
    assign wr_trig  = bus_we && rdy && (bus_addr == AW'(A_TRIG));
    assign wr_match = bus_we && rdy && (bus_addr == AW'(A_MATCH));
    assign wr_ifc   = bus_we && rdy && (bus_addr == AW'(A_IFC));

    assign srst_go = wr_ifc && bus_wdata[1];
    assign clr     = (state == ST_SRST) || srst_go;

    // ---------------- soft-reset state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_READY: if (srst_go)   state_nxt = ST_SRST;   // go_reset
            ST_SRST:  if (cd == '0)  state_nxt = ST_READY;  // reset_done
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cd <= '0;
        else if (srst_go)                     cd <= CD_W'(SRST_CYCLES - 1);
        else if (state == ST_SRST && cd != 0) cd <= cd - 1'b1;
    end

    always_comb begin
        rdy = (state == ST_READY);
    end

    // ---------------- count path ----------------
    dmt_prescale #(.PV_W(PV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .run     (ctrl.run),
        .pre_en  (ctrl.pre_en),
        .pre_val (ctrl.pre_val),
        .tick    (tick)
    );

    assign at_top    = (cnt == '1);
    assign cnt_wr    = wr_cnt || wr_trig;
    assign cnt_adv   = at_top ? (ctrl.reload ? load_v : '0) : cnt + 1'b1;
    assign ovf_evt   = tick && at_top && !cnt_wr;
    assign match_evt = tick && ctrl.cmp_en && !cnt_wr && (cnt_adv == match_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (wr_cnt)   cnt <= bus_wdata;
        else if (wr_trig)  cnt <= load_v;
        else if (tick)     cnt <= cnt_adv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         ctrl <= '0;
        else if (clr)                       ctrl <= '0;
        else if (wr_ctrl)                   ctrl <= ctrl_t'(bus_wdata[CW-1:0]);
        else if (ovf_evt && !ctrl.reload)   ctrl.run <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_v  <= '0;
            match_v <= '0;
            ien     <= '0;
            wen     <= '0;
        end else if (clr) begin
            load_v  <= '0;
            match_v <= '0;
            ien     <= '0;
            wen     <= '0;
        end else begin
            if (wr_load)  load_v  <= bus_wdata;
            if (wr_match) match_v <= bus_wdata;
            if (wr_ien)   ien     <= bus_wdata[STAT_W-1:0];
            if (wr_wen)   wen     <= bus_wdata[STAT_W-1:0];
        end
    end

    // ---------------- capture ----------------
    dmt_capsync u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (capt_i),
        .edge_sel (ctrl.edge_sel),
        .hit      (cap_hit)
    );

    assign cap_take = cap_hit && !(ctrl.cap_hold && stat[S_CAPT]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        capt_v <= '0;
        else if (clr)      capt_v <= '0;
        else if (cap_take) capt_v <= cnt;
    end

    // ---------------- status: events win over clears ----------------
    always_comb begin
        stat_clr = wr_stat ? bus_wdata[STAT_W-1:0] : '0;
        stat_set = '0;
        stat_set[S_MATCH] = match_evt;
        stat_set[S_OVF]   = ovf_evt;
        stat_set[S_CAPT]  = cap_take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   stat <= '0;
        else if (clr) stat <= '0;
        else          stat <= (stat & ~stat_clr) | stat_set;
    end

    assign irq_o  = |(stat & ien);
    assign wake_o = |(stat & wen);

    // ---------------- output pin ----------------
    dmt_pwm u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .def_lvl   (ctrl.def_lvl),
        .gpo       (ctrl.gpo),
        .toggle    (ctrl.toggle),
        .trig_mode (ctrl.trig_mode),
        .ovf_evt   (ovf_evt),
        .match_evt (match_evt),
        .pwm_o     (pwm_o)
    );

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_SYSST): bus_rdata = DW'(rdy);
            AW'(A_STAT):  bus_rdata = DW'(stat);
            AW'(A_IEN):   bus_rdata = DW'(ien);
            AW'(A_WEN):   bus_rdata = DW'(wen);
            AW'(A_CTRL):  bus_rdata = DW'(ctrl);
            AW'(A_CNT):   bus_rdata = cnt;
            AW'(A_LOAD):  bus_rdata = load_v;
            AW'(A_MATCH): bus_rdata = match_v;
            AW'(A_CAPT):  bus_rdata = capt_v;
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmt_timer_chk.sv
module dmt_timer_chk
    import dmt_pkg::*;
#(
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input ctrl_t             ctrl,
    input logic [DW-1:0]     cnt,
    input logic [STAT_W-1:0] stat,
    input logic [STAT_W-1:0] ien,
    input logic              tick,
    input logic              ovf_evt,
    input logic              match_evt,
    input logic              srst_go,
    input logic              rdy,
    input logic              pwm_o,
    input logic              irq_o
);
    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !bus_we && rdy) |=> $stable(cnt));

    // R5
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt == '1) && !ctrl.reload && !bus_we) |=> !ctrl.run);

    // R10
    match_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> stat[S_MATCH]);

    // R11
    ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && ien[S_OVF] && !bus_we) |=> irq_o);

    // R12
    pulse_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !bus_we && ctrl.trig_mode != 2'b00 && !ctrl.toggle && !ctrl.gpo)
        |=> (pwm_o != ctrl.def_lvl));

    // R14
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_go |=> (ctrl == '0 && cnt == '0 && stat == '0 && !rdy));
endmodule

bind dmt_timer dmt_timer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .ctrl      (ctrl),
    .cnt       (cnt),
    .stat      (stat),
    .ien       (ien),
    .tick      (tick),
    .ovf_evt   (ovf_evt),
    .match_evt (match_evt),
    .srst_go   (srst_go),
    .rdy       (rdy),
    .pwm_o     (pwm_o),
    .irq_o     (irq_o)
);

// File: tb/dmt_timer_bench.sv
`timescale 1ns/1ps
module dmt_timer_bench;
    localparam int SRST_N = 4;

    localparam logic [7:0] SYSST = 8'h14, STAT = 8'h18, IEN = 8'h1C, WEN = 8'h20,
                           CTRL = 8'h24, CNT = 8'h28, LOAD = 8'h2C, TRIG = 8'h30,
                           MATCH = 8'h38, CAPT = 8'h3C, IFC = 8'h40;

    localparam logic [31:0] C_RUN = 32'h1,   C_AR = 32'h2,    C_PRE = 32'h20,
                            C_CE = 32'h40,   C_DEF = 32'h80,  C_RISE = 32'h100,
                            C_FALL = 32'h200, C_TOVF = 32'h400, C_TBOTH = 32'h800,
                            C_TOG = 32'h1000, C_HOLD = 32'h2000, C_GPO = 32'h4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        capt_i;
    logic        pwm_o, irq_o, wake_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    dmt_timer #(.AW(8), .DW(32), .SRST_CYCLES(SRST_N)) u_dmt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .capt_i    (capt_i),
        .pwm_o     (pwm_o),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // entered at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    function automatic logic [31:0] ticks(input int n, input logic pe, input logic [2:0] pv);
        return pe ? 32'(n >> (pv + 1)) : 32'(n);
    endfunction

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d, ctl, v0, m;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; capt_i = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rchk("R1 ctrl", CTRL, 0);
        rchk("R1 cnt", CNT, 0);
        rchk("R1 load", LOAD, 0);
        rchk("R1 match", MATCH, 0);
        rchk("R1 stat", STAT, 0);
        rchk("R1 capt", CAPT, 0);
        rchk("R1 sysst", SYSST, 1);
        chk("R1 pins", {29'd0, irq_o, wake_o, pwm_o}, 0);

        // R2 run k+1 edges, no prescale
        wr(CNT, 32'd1000);
        wr(CTRL, C_RUN);
        idle(6);
        wr(CTRL, 0);
        rchk("R2 count", CNT, 32'd1007);
        idle(5);
        rchk("R2 hold", CNT, 32'd1007);

        // R2 bus write beats a tick
        wr(CTRL, C_RUN);
        idle(3);
        wr(CNT, 32'd100);
        wr(CTRL, 0);
        rchk("R2 write wins", CNT, 32'd101);

        // R3 random runs with and without prescaler
        for (int it = 0; it < 12; it++) begin
            int k;
            logic pe;
            logic [2:0] pv;
            v0 = $urandom & 32'h7fff_ffff;
            k  = $urandom_range(1, 40);
            pe = 1'($urandom_range(0, 1));
            pv = 3'($urandom_range(0, 2));
            ctl = C_RUN | (pe ? C_PRE : 32'd0) | (32'(pv) << 2);
            wr(CNT, v0);
            wr(CTRL, ctl);
            idle(k);
            wr(CTRL, ctl & ~C_RUN);
            rchk("R3 prescaled count", CNT, v0 + ticks(k + 1, pe, pv));
        end

        // R6 trigger copies load, data ignored
        wr(LOAD, 32'h1234_5678);
        wr(TRIG, 32'hDEAD_BEEF);
        rchk("R6 trigger", CNT, 32'h1234_5678);

        // R4 overflow with reload
        wr(STAT, 32'h7);
        wr(CNT, 32'hFFFF_FFFD);
        wr(LOAD, 32'h0000_0A00);
        wr(CTRL, C_RUN | C_AR);
        idle(2);
        wr(CTRL, C_AR);
        rchk("R4 reload", CNT, 32'h0000_0A00);
        rchk("R4 ovf bit", STAT, 32'h2);

        // R5 one-shot wrap and halt; R12 toggle on overflow
        wr(STAT, 32'h7);
        wr(CNT, 32'hFFFF_FFFE);
        wr(CTRL, C_RUN | C_TOG | C_TOVF);
        chk("R13 idle pwm at default", {31'd0, pwm_o}, 0);
        idle(4);
        rchk("R5 wrap", CNT, 0);
        rchk("R5 run cleared", CTRL, C_TOG | C_TOVF);
        chk("R12 toggled on overflow", {31'd0, pwm_o}, 1);

        // R12 match does not toggle in overflow-only mode
        wr(MATCH, 32'd50);
        wr(CNT, 32'd48);
        wr(CTRL, C_RUN | C_CE | C_TOG | C_TOVF);
        idle(3);
        wr(CTRL, C_CE | C_TOG | C_TOVF);
        chk("R12 no toggle on match", {31'd0, pwm_o}, 1);
        rchk("R7 match bit", STAT, 32'h3);

        // R7 compare disabled
        wr(STAT, 32'h7);
        wr(CNT, 32'd48);
        wr(CTRL, C_RUN);
        idle(3);
        wr(CTRL, 0);
        rchk("R7 no match when disabled", STAT, 0);
        chk("R13 trig none pwm default", {31'd0, pwm_o}, 0);

        // R12 pulse on match, default level high
        m = 32'd300;
        wr(MATCH, m);
        wr(CNT, m - 2);
        wr(CTRL, C_RUN | C_CE | C_DEF | C_TBOTH);
        idle(1);
        chk("R12 before pulse", {31'd0, pwm_o}, 1);
        idle(1);
        chk("R12 pulse", {31'd0, pwm_o}, 0);
        idle(1);
        chk("R12 after pulse", {31'd0, pwm_o}, 1);
        wr(CTRL, C_DEF);

        // R13 general-purpose output
        wr(CTRL, C_GPO | C_DEF | C_TOG | C_TBOTH);
        chk("R13 gpo high", {31'd0, pwm_o}, 1);
        wr(CTRL, C_GPO);
        chk("R13 gpo low", {31'd0, pwm_o}, 0);

        // R8 capture edges (counter stopped)
        wr(STAT, 32'h7);
        wr(CNT, 32'd11);
        wr(CTRL, C_RISE);
        capt_i = 1'b1; idle(5);
        rchk("R8 rise capt", CAPT, 32'd11);
        rchk("R8 rise stat", STAT, 32'h4);
        wr(STAT, 32'h4);
        wr(CNT, 32'd22);
        capt_i = 1'b0; idle(5);
        rchk("R8 fall ignored capt", CAPT, 32'd11);
        rchk("R8 fall ignored stat", STAT, 0);
        wr(CTRL, C_FALL);
        capt_i = 1'b1; idle(5);
        rchk("R8 rise ignored", CAPT, 32'd11);
        capt_i = 1'b0; idle(5);
        rchk("R8 fall capt", CAPT, 32'd22);
        wr(CTRL, C_RISE | C_FALL);
        wr(CNT, 32'd33);
        capt_i = 1'b1; idle(5);
        rchk("R8 both capt", CAPT, 32'd33);

        // R9 hold first capture while bit 2 set
        wr(CTRL, C_RISE | C_FALL | C_HOLD);
        wr(CNT, 32'd44);
        capt_i = 1'b0; idle(5);
        rchk("R9 held", CAPT, 32'd33);
        wr(STAT, 32'h4);
        capt_i = 1'b1; idle(5);
        rchk("R9 after clear", CAPT, 32'd44);
        wr(CTRL, 0);

        // R10 set beats clear on the same edge; bit 2 set from capture
        m = 32'd700;
        wr(MATCH, m);
        wr(CNT, m - 3);
        wr(CTRL, C_RUN | C_CE);
        idle(2);
        wr(STAT, 32'h5);
        wr(CTRL, 0);
        rchk("R10 set wins", STAT, 32'h1);

        // R11 interrupt and wakeup masking
        wr(IEN, 32'h2);
        chk("R11 irq masked", {31'd0, irq_o}, 0);
        wr(IEN, 32'h1);
        chk("R11 irq on", {31'd0, irq_o}, 1);
        wr(WEN, 32'h4);
        chk("R11 wake masked", {31'd0, wake_o}, 0);
        wr(WEN, 32'h1);
        chk("R11 wake on", {31'd0, wake_o}, 1);
        wr(STAT, 32'h1);
        chk("R10 clear drops irq", {31'd0, irq_o}, 0);

        // R14 soft reset
        wr(CTRL, C_AR | C_CE);
        wr(IFC, 32'h6);
        rchk("R14 busy", SYSST, 0);
        wr(LOAD, 32'h55);
        idle(SRST_N + 1);
        rchk("R14 done", SYSST, 1);
        rchk("R14 ctrl cleared", CTRL, 0);
        rchk("R14 cnt cleared", CNT, 0);
        rchk("R14 write ignored", LOAD, 0);
        rchk("R14 ien cleared", IEN, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule